// File: doc/BRIEF.md
# Defect Recovery Action Dispatcher

This block sits at the chip-level end of a hardware defect-patching network. Detection units spread over the chip match programmed defect signatures. Hubs gather their detection events, one hub per neighbourhood. Each hub presents a request together with the 2-bit defect class stored with the matched signature. The dispatcher takes one event at a time and chooses a single recovery action from that class and from a checkpoint-support configuration bit. It then drives that action to the owning agent as a request held until acknowledged. There are four actions: switch off the triggering condition and resume, flush the pipeline, roll back to a checkpoint, or interrupt the operating system.

When several hubs request together, a round-robin arbiter picks one. The chosen hub sees a grant in the cycle its event is taken and then drops its request. Other hubs keep their requests raised until they are served. A saturating counter for each action records how many times that action has completed. A select input reads any one of the counters for debug.

Top module: `rcv_dispatch`

## Requirements
- R1: After reset no action request, grant or busy is asserted, and all four action counters read zero.
- R2: Class 2'b00 (caught before the defect took effect) raises only `condOffReq`, whatever the checkpoint setting.
- R3: Class 2'b01 (after the defect, confined to the pipeline) raises only `flushReq`, whatever the checkpoint setting.
- R4: Class 2'b10 or 2'b11 (after the defect, not confined) raises only `rollbackReq` when `ckptPresent` was 1 at acceptance.
- R5: Class 2'b10 or 2'b11 raises only `osIntReq` when `ckptPresent` was 0 at acceptance.
- R6: `ckptPresent` is sampled only in the accepting cycle; changing it while an event is in service leaves the chosen action unchanged.
- R7: At most one action request is high at a time. It stays high and unchanged until its own acknowledge arrives. Acknowledges of the other actions are ignored.
- R8: `busy` is high from the cycle after acceptance until the edge at which the active acknowledge is seen. No grant is issued while busy.
- R9: Among simultaneous requesters, the grant goes to the first requesting hub after the last granted hub, in increasing index order with wrap-around. Straight after reset the search starts at hub 0.
- R10: At most one bit of `hubGrant` is high, only for a requesting hub, and only in a cycle where the event is accepted.
- R11: The counter of the completed action increments at the acknowledge edge. `cntSel` selects which counter is read: 0 condition-off, 1 flush, 2 rollback, 3 interrupt. A counter at all-ones stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hubReq | input | NUM_HUBS | Pending detection event per hub |
| hubType | input | 2*NUM_HUBS | Defect class per hub, hub i at bits [2i+1:2i] |
| ckptPresent | input | 1 | Checkpoint support available |
| hubGrant | output | NUM_HUBS | One-hot: event of this hub is accepted this cycle |
| busy | output | 1 | An event is in service |
| condOffReq | output | 1 | Request to switch off the triggering condition |
| flushReq | output | 1 | Request to flush the pipeline |
| rollbackReq | output | 1 | Request to roll back to a checkpoint |
| osIntReq | output | 1 | Request to interrupt the operating system |
| condOffAck | input | 1 | Acknowledge of condition switch-off |
| flushAck | input | 1 | Acknowledge of flush |
| rollbackAck | input | 1 | Acknowledge of rollback |
| osIntAck | input | 1 | Acknowledge of interrupt |
| cntSel | input | 2 | Counter read select |
| cntValue | output | CNT_W | Selected action counter |

## Verification
`hubGrant` is combinational and is due in the same cycle as the request it answers. The action request and `busy` appear one edge after acceptance. Their release and the counter step appear one edge after the matching acknowledge. The bench changes inputs on the falling edge. It reads the grant 1 ns later, in the same cycle, and reads every registered result at the next falling edge, after exactly one rising edge. It reads the counter 1 ns after setting the select, since the read path is combinational.

// File: rtl/rcv_disp_pkg.sv
package rcv_disp_pkg;
  typedef enum logic [1:0] {
    DEF_PRE        = 2'b00,
    DEF_POST_PIPE  = 2'b01,
    DEF_POST_OTHER = 2'b10,
    DEF_RESERVED   = 2'b11
  } defect_e;

  localparam int NUM_ACT      = 4;
  localparam int ACT_CONDOFF  = 0;
  localparam int ACT_FLUSH    = 1;
  localparam int ACT_ROLLBACK = 2;
  localparam int ACT_OSINT    = 3;

  typedef struct packed {
    logic accept;
    logic done;
  } ctl_strobe_t;
endpackage

// File: rtl/rcv_rr_arbiter.sv
module rcv_rr_arbiter #(
  parameter int NUM_HUBS = 4,
  localparam int IDX_W = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_HUBS-1:0] reqVec,
  input  logic                advance,
  output logic [NUM_HUBS-1:0] grantVec,
  output logic [IDX_W-1:0]    grantIdx,
  output logic                anyReq
);
  logic [IDX_W-1:0] lastIdx;

  always_comb begin
    logic found;
    found    = 1'b0;
    grantVec = '0;
    grantIdx = '0;
    for (int off = 1; off <= NUM_HUBS; off++) begin
      int cand;
      cand = int'(lastIdx) + off;
      if (cand >= NUM_HUBS) cand = cand - NUM_HUBS;
      if (!found && reqVec[cand]) begin
        found          = 1'b1;
        grantVec[cand] = 1'b1;
        grantIdx       = IDX_W'(cand);
      end
    end
  end

  assign anyReq = |reqVec;

  always_ff @(posedge clk) begin
    if (!rst_n) lastIdx <= IDX_W'(NUM_HUBS - 1);
    else if (advance) lastIdx <= grantIdx;
  end

  // R10
  grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grantVec));
  // R10
  grant_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grantVec & ~reqVec) == '0);
endmodule

// File: rtl/rcv_ctrl.sv
module rcv_ctrl
  import rcv_disp_pkg::*;
#(
  parameter int NUM_HUBS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                anyReq,
  input  logic [NUM_HUBS-1:0] grantVec,
  input  logic                actAck,
  output ctl_strobe_t         strobe,
  output logic                busy,
  output logic [NUM_HUBS-1:0] hubGrant
);
  always_comb begin
    strobe.accept = !busy && anyReq;
    strobe.done   = busy && actAck;
  end

  assign hubGrant = busy ? '0 : grantVec;

  always_ff @(posedge clk) begin
    if (!rst_n) busy <= 1'b0;
    else if (strobe.accept) busy <= 1'b1;
    else if (strobe.done) busy <= 1'b0;
  end

  // R8
  no_grant_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> hubGrant == '0);
  // R8
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !actAck) |=> busy);
  // R8
  busy_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && actAck) |=> !busy);
endmodule

// File: rtl/rcv_datapath.sv
module rcv_datapath
  import rcv_disp_pkg::*;
#(
  parameter int NUM_HUBS = 4,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  ctl_strobe_t           strobe,
  input  logic [IDX_W-1:0]      grantIdx,
  input  logic [2*NUM_HUBS-1:0] hubTypeFlat,
  input  logic                  ckptPresent,
  input  logic [NUM_ACT-1:0]    ackVec,
  input  logic [1:0]            cntSel,
  output logic [NUM_ACT-1:0]    actVec,
  output logic                  actAck,
  output logic [CNT_W-1:0]      cntValue
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  defect_e            selType;
  logic [NUM_ACT-1:0] nextAct;
  logic [CNT_W-1:0]   cntQ [NUM_ACT];

  assign selType = defect_e'(hubTypeFlat[int'(grantIdx)*2 +: 2]);

  always_comb begin
    nextAct = '0;
    unique case (selType)
      DEF_PRE:       nextAct[ACT_CONDOFF] = 1'b1;
      DEF_POST_PIPE: nextAct[ACT_FLUSH]   = 1'b1;
      default: begin
        if (ckptPresent) nextAct[ACT_ROLLBACK] = 1'b1;
        else             nextAct[ACT_OSINT]    = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) actVec <= '0;
    else if (strobe.accept) actVec <= nextAct;
    else if (strobe.done) actVec <= '0;
  end

  assign actAck = |(actVec & ackVec);

  for (genvar g = 0; g < NUM_ACT; g++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (!rst_n) cntQ[g] <= '0;
      else if (strobe.done && actVec[g] && cntQ[g] != CNT_MAX)
        cntQ[g] <= cntQ[g] + 1'b1;
    end

    // R11
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cntQ[g] == CNT_MAX |=> cntQ[g] == CNT_MAX);
  end

  assign cntValue = cntQ[cntSel];

  // R7
  one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(actVec));
  // R7
  act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (actVec != '0 && !actAck) |=> $stable(actVec));
endmodule

// File: rtl/rcv_dispatch.sv
module rcv_dispatch
  import rcv_disp_pkg::*;
#(
  parameter int NUM_HUBS = 4,
  parameter int CNT_W    = 8,
  localparam int IDX_W   = (NUM_HUBS > 1) ? $clog2(NUM_HUBS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_HUBS-1:0]   hubReq,
  input  logic [2*NUM_HUBS-1:0] hubType,
  input  logic                  ckptPresent,
  output logic [NUM_HUBS-1:0]   hubGrant,
  output logic                  busy,
  output logic                  condOffReq,
  output logic                  flushReq,
  output logic                  rollbackReq,
  output logic                  osIntReq,
  input  logic                  condOffAck,
  input  logic                  flushAck,
  input  logic                  rollbackAck,
  input  logic                  osIntAck,
  input  logic [1:0]            cntSel,
  output logic [CNT_W-1:0]      cntValue
);
  ctl_strobe_t        strobe;
  logic [NUM_HUBS-1:0] grantVec;
  logic [IDX_W-1:0]   grantIdx;
  logic               anyReq;
  logic               actAck;
  logic [NUM_ACT-1:0] actVec;
  logic [NUM_ACT-1:0] ackVec;

  always_comb begin
    ackVec               = '0;
    ackVec[ACT_CONDOFF]  = condOffAck;
    ackVec[ACT_FLUSH]    = flushAck;
    ackVec[ACT_ROLLBACK] = rollbackAck;
    ackVec[ACT_OSINT]    = osIntAck;
  end

  rcv_rr_arbiter #(.NUM_HUBS(NUM_HUBS)) u_arb (
    .clk(clk), .rst_n(rst_n), .reqVec(hubReq), .advance(strobe.accept),
    .grantVec(grantVec), .grantIdx(grantIdx), .anyReq(anyReq)
  );

  rcv_ctrl #(.NUM_HUBS(NUM_HUBS)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .anyReq(anyReq), .grantVec(grantVec),
    .actAck(actAck), .strobe(strobe), .busy(busy), .hubGrant(hubGrant)
  );

  rcv_datapath #(.NUM_HUBS(NUM_HUBS), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .grantIdx(grantIdx),
    .hubTypeFlat(hubType), .ckptPresent(ckptPresent), .ackVec(ackVec),
    .cntSel(cntSel), .actVec(actVec), .actAck(actAck), .cntValue(cntValue)
  );

  assign condOffReq  = actVec[ACT_CONDOFF];
  assign flushReq    = actVec[ACT_FLUSH];
  assign rollbackReq = actVec[ACT_ROLLBACK];
  assign osIntReq    = actVec[ACT_OSINT];

  // R8
  busy_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == (actVec != '0));
  // R6
  ckpt_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !actAck) |=> $stable({rollbackReq, osIntReq}));
endmodule

// File: tb/rcv_dispatch_tb.sv
`timescale 1ns/1ps
module rcv_dispatch_tb;
  localparam int N  = 4;
  localparam int CW = 8;
  localparam int CMAX = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] hubReq;
  logic [2*N-1:0] hubType;
  logic ckptPresent;
  logic [N-1:0] hubGrant;
  logic busy, condOffReq, flushReq, rollbackReq, osIntReq;
  logic condOffAck, flushAck, rollbackAck, osIntAck;
  logic [1:0] cntSel;
  logic [CW-1:0] cntValue;

  int checks = 0;
  int errors = 0;
  int expCnt[4];
  bit finished = 0;

  always #2 clk = ~clk;

  rcv_dispatch #(.NUM_HUBS(N), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hubReq(hubReq), .hubType(hubType),
    .ckptPresent(ckptPresent), .hubGrant(hubGrant), .busy(busy),
    .condOffReq(condOffReq), .flushReq(flushReq), .rollbackReq(rollbackReq),
    .osIntReq(osIntReq), .condOffAck(condOffAck), .flushAck(flushAck),
    .rollbackAck(rollbackAck), .osIntAck(osIntAck), .cntSel(cntSel),
    .cntValue(cntValue)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] reqs();
    return {osIntReq, rollbackReq, flushReq, condOffReq};
  endfunction

  task automatic setAck(logic [3:0] a);
    {osIntAck, rollbackAck, flushAck, condOffAck} = a;
  endtask

  task automatic readCnt(int a, int exp, string tag);
    cntSel = 2'(a);
    #1 chk(tag, 32'(cntValue), 32'(exp));
  endtask

  task automatic doReset();
    rst_n = 1'b0; hubReq = '0; hubType = '0; ckptPresent = 1'b0;
    setAck(4'b0000); cntSel = 2'd0;
    for (int i = 0; i < 4; i++) expCnt[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 reqs", 32'(reqs()), 0);
    chk("R1 busy", 32'(busy), 0);
    chk("R1 grant", 32'(hubGrant), 0);
    for (int i = 0; i < 4; i++) readCnt(i, 0, "R1 counter");
  endtask

  // Single event: grant, action, hold under foreign acks, release, count
  task automatic runEvent(int hub, logic [1:0] ty, logic ck, int act, string tag);
    @(negedge clk);
    hubReq[hub] = 1'b1;
    hubType[2*hub +: 2] = ty;
    ckptPresent = ck;
    #1 chk("R10 grant", 32'(hubGrant), 32'(1 << hub));
    @(negedge clk);
    hubReq[hub] = 1'b0;
    ckptPresent = ~ck; // R6: late change must not matter
    chk("R8 busy set", 32'(busy), 1);
    chk(tag, 32'(reqs()), 32'(1 << act));
    setAck(~(4'(1) << act));
    @(negedge clk);
    chk("R7 hold", 32'(reqs()), 32'(1 << act));
    chk("R6 action kept", 32'(reqs()), 32'(1 << act));
    setAck(4'(1) << act);
    @(negedge clk);
    setAck(4'b0000);
    chk("R8 busy clear", 32'(busy), 0);
    chk("R7 release", 32'(reqs()), 0);
    if (expCnt[act] < CMAX) expCnt[act]++;
    readCnt(act, expCnt[act], "R11 count");
  endtask

  task automatic serveHub(int hub);
    @(negedge clk);
    hubReq[hub] = 1'b0;
    #1 chk("R8 no grant while busy", 32'(hubGrant), 0);
    chk("R2 pre action", 32'(reqs()), 1);
    setAck(4'b0001);
    @(negedge clk);
    setAck(4'b0000);
    expCnt[0]++;
  endtask

  task automatic testClasses();
    doReset();
    runEvent(0, 2'b00, 1'b0, 0, "R2 pre");
    runEvent(2, 2'b00, 1'b1, 0, "R2 pre ckpt");
    runEvent(1, 2'b01, 1'b1, 1, "R3 pipe");
    runEvent(3, 2'b01, 1'b0, 1, "R3 pipe nockpt");
    runEvent(2, 2'b10, 1'b1, 2, "R4 rollback");
    runEvent(0, 2'b11, 1'b1, 2, "R4 rollback rsvd");
    runEvent(1, 2'b10, 1'b0, 3, "R5 osint");
    runEvent(3, 2'b11, 1'b0, 3, "R5 osint rsvd");
    readCnt(0, 2, "R11 condoff total");
    readCnt(1, 2, "R11 flush total");
    readCnt(2, 2, "R11 rollback total");
    readCnt(3, 2, "R11 osint total");
  endtask

  task automatic testRoundRobin();
    doReset();
    @(negedge clk);
    hubType = '0;
    hubReq = 4'b1010;
    #1 chk("R9 first from hub0", 32'(hubGrant), 32'h2);
    serveHub(1);
    hubReq = hubReq | 4'b0011;
    #1 chk("R9 after hub1", 32'(hubGrant), 32'h8);
    serveHub(3);
    #1 chk("R9 wrap to hub0", 32'(hubGrant), 32'h1);
    serveHub(0);
    #1 chk("R9 then hub1", 32'(hubGrant), 32'h2);
    serveHub(1);
    #1 chk("R10 idle no grant", 32'(hubGrant), 0);
    readCnt(0, 4, "R11 rr count");
  endtask

  task automatic testSaturation();
    doReset();
    for (int i = 0; i < CMAX + 4; i++) runEvent(i % N, 2'b00, 1'b1, 0, "R2 sat pre");
    readCnt(0, CMAX, "R11 saturated");
    readCnt(1, 0, "R11 other untouched");
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    testClasses();
    testRoundRobin();
    testSaturation();
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end
endmodule